// File: doc/BRIEF.md
# Successive-Approximation Conversion Controller with Auto-Compare

This block is the digital sequencer that sits beside the analog core of a successive-approximation converter. A single control write loads the channel, the conversion clock source, the clock divider, the trigger selection, the continuous-mode bit and the compare settings. The same write either starts a conversion (software trigger) or arms the block so that a rising edge on the hardware trigger input starts one. The sequencer drives a trial code to the on-chip DAC, samples the comparator answer once per divided conversion clock, and assembles the result MSB first.

The conversion logic runs on a clock chosen from four sources: the bus clock, the bus clock halved, an alternate clock input and a free-running asynchronous clock. The chosen clock is divided by 1, 2, 4 or 8. Start and abort events cross into the conversion domain, and completion events cross back, through toggle-based two-flop synchronizers. Result data and status stay on the bus side.

With the compare function enabled, a finished conversion is checked against a programmed threshold. The test is either "result at or above threshold" or "result below threshold". Only a true compare stores the result and raises the completion flag. In continuous mode the block keeps converting without raising anything until a conversion meets the condition.

Top module: `sar_conv_ctrl`

## Requirements
- R1: The conversion clock source follows the 2-bit source field: 0 bus clock, 1 bus clock divided by 2, 2 alternate clock input, 3 asynchronous clock input. Conversions complete with a correct result on every source, and a conversion on source 1 lasts twice as many bus cycles as one on source 0.
- R2: The 2-bit divider field code d divides the chosen clock by 2^d. A conversion keeps `conv_active` high for RES_W x 2^d conversion clock cycles.
- R3: The result is resolved one bit per divided clock, MSB first. A trial bit is kept when `cmp_in` is 1 (input at or above `dac_code`), so the stored result equals the analog code across the full range 0 to 2^RES_W-1.
- R4: A `ctrl_wr` pulse with `hw_trig_en`=0 starts a conversion. A `ctrl_wr` pulse with `hw_trig_en`=1 starts nothing and leaves the block idle.
- R5: When armed with `hw_trig_en`=1, a rising edge on `hw_trig` starts a conversion. A rising edge that arrives while `busy` is high is ignored.
- R6: The channel code is captured at the start of a conversion onto `sample_chan`. `mux_en` is 1 for codes 0 to 13 and 0 for the reserved codes 14 and 15.
- R7: With `cmp_en`=1, `cmp_ge`=1 accepts result >= `cmp_val` and `cmp_ge`=0 accepts result < `cmp_val`. On a false compare neither `done_flag` nor `result` changes. With `cmp_en`=0 every conversion is accepted.
- R8: With `cont_en`=1 and the compare enabled, conversions repeat with `busy` held at 1 and `done_flag` at 0 until one meets the compare. That conversion then sets `done_flag` and stores its result.
- R9: `done_flag` clears on a `rslt_rd` pulse and on any `ctrl_wr` pulse.
- R10: After reset `done_flag`, `busy`, `result`, `dac_code` and `conv_active` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| alt_clk | input | 1 | Alternate conversion clock source |
| async_clk | input | 1 | Free-running asynchronous conversion clock source |
| ctrl_wr | input | 1 | Control write strobe; loads all settings below |
| chan_sel | input | CH_W | Channel code to convert |
| clk_src | input | 2 | Conversion clock source select |
| clk_div | input | 2 | Divider code, ratio 2^code |
| hw_trig_en | input | 1 | 1 selects hardware trigger, 0 selects software start |
| cont_en | input | 1 | Continuous conversion |
| cmp_en | input | 1 | Enable auto-compare |
| cmp_ge | input | 1 | 1 accepts at-or-above threshold, 0 accepts below |
| cmp_val | input | RES_W | Compare threshold |
| hw_trig | input | 1 | Hardware trigger, rising edge active |
| rslt_rd | input | 1 | Result read strobe, clears the flag |
| cmp_in | input | 1 | Comparator answer from the analog core |
| dac_code | output | RES_W | Trial code to the DAC |
| sample_chan | output | CH_W | Channel code applied to the input multiplexer |
| mux_en | output | 1 | Multiplexer enable, low for reserved codes |
| conv_active | output | 1 | Conversion-domain sequence in progress |
| busy | output | 1 | Bus-side view of a running conversion sequence |
| done_flag | output | 1 | Conversion-complete flag |
| result | output | RES_W | Stored conversion result |

## Verification
A table of analog codes drives a behavioural comparator. Its entries place the input at zero, at full scale, on an alternating bit pattern, and exactly on or one code below the threshold. These points separate a missed MSB or LSB decision from a wrong keep rule, and an inclusive compare boundary from an exclusive one for both compare senses. The same table cycles through all four clock sources and several divider codes. Separate timing runs on the bus clock measure the active window for each divider code and for the halved source, so they can tell a wrong ratio from an off-by-one. Directed sequences cover the hardware trigger with a second edge while busy, a software write in trigger mode, a continuous compare whose input later crosses the threshold, and reserved channel codes.

// File: rtl/adc_ctl_pkg.sv
package adc_ctl_pkg;

  typedef enum logic [1:0] {
    SRC_BUS      = 2'd0,
    SRC_BUS_HALF = 2'd1,
    SRC_ALT      = 2'd2,
    SRC_ASYNC    = 2'd3
  } clk_src_e;

  // Divide ratio for a 2-bit divider code: 1, 2, 4 or 8.
  function automatic logic [3:0] div_ratio(input logic [1:0] code);
    return 4'd1 << code;
  endfunction

  // Auto-compare decision on zero-extended operands.
  function automatic logic cmp_hit(input logic [15:0] res,
                                   input logic [15:0] thr,
                                   input logic        at_or_above);
    return at_or_above ? (res >= thr) : (res < thr);
  endfunction

endpackage

// File: rtl/conv_clk_sel.sv
module conv_clk_sel
  import adc_ctl_pkg::*;
(
  input  logic     bus_clk,
  input  logic     rst_n,
  input  logic     alt_clk,
  input  logic     async_clk,
  input  clk_src_e src,
  output logic     conv_clk
);

  logic half_q;

  always_ff @(posedge bus_clk or negedge rst_n) begin
    if (!rst_n) half_q <= 1'b0;
    else        half_q <= ~half_q;
  end

  // Source is only changed while idle, so the plain mux is acceptable.
  always_comb begin
    case (src)
      SRC_BUS:      conv_clk = bus_clk;
      SRC_BUS_HALF: conv_clk = half_q;
      SRC_ALT:      conv_clk = alt_clk;
      default:      conv_clk = async_clk;
    endcase
  end

endmodule

// File: rtl/tgl_sync.sv
module tgl_sync #(
  parameter int STAGES = 2
) (
  input  logic dst_clk,
  input  logic rst_n,
  input  logic tgl_in,
  output logic pulse
);

  logic [STAGES:0] pipe;

  always_ff @(posedge dst_clk or negedge rst_n) begin
    if (!rst_n) pipe <= '0;
    else        pipe <= {pipe[STAGES-1:0], tgl_in};
  end

  assign pulse = pipe[STAGES] ^ pipe[STAGES-1];

endmodule

// File: rtl/sar_engine.sv
module sar_engine
  import adc_ctl_pkg::*;
#(
  parameter int RES_W   = 10,
  parameter int CH_W    = 4,
  parameter int NUM_SRC = 14
) (
  input  logic             conv_clk,
  input  logic             rst_n,
  input  logic             go_pulse,
  input  logic             go_start,
  input  logic [1:0]       div_code,
  input  logic             cont_en,
  input  logic             cmp_en,
  input  logic             cmp_ge,
  input  logic [RES_W-1:0] cmp_val,
  input  logic [CH_W-1:0]  chan_sel,
  input  logic             cmp_in,
  output logic [RES_W-1:0] dac_code,
  output logic             active,
  output logic [CH_W-1:0]  sample_chan,
  output logic             mux_en,
  output logic [RES_W-1:0] trial,
  output logic             end_tgl,
  output logic             end_pass,
  output logic             end_last,
  output logic [RES_W-1:0] end_data
);

  localparam logic [RES_W-1:0] MSB_ONLY = {1'b1, {(RES_W-1){1'b0}}};
  localparam logic [CH_W-1:0]  SRC_LAST = CH_W'(NUM_SRC - 1);

  logic [RES_W-1:0] acc;
  logic [RES_W-1:0] acc_next;
  logic [RES_W-1:0] val_l;
  logic [2:0]       cnt;
  logic [1:0]       div_l;
  logic             cont_l;
  logic             ce_l;
  logic             ge_l;
  logic             tick;
  logic             last_bit;
  logic             hit;

  // Named internal events.
  assign tick     = active && ({1'b0, cnt} == (div_ratio(div_l) - 4'd1));
  assign acc_next = cmp_in ? (acc | trial) : acc;
  assign last_bit = trial[0];
  assign hit      = !ce_l || cmp_hit(16'(acc_next), 16'(val_l), ge_l);
  assign dac_code = acc | trial;
  assign mux_en   = (sample_chan <= SRC_LAST);

  // Settings captured at start.
  always_ff @(posedge conv_clk or negedge rst_n) begin
    if (!rst_n) begin
      div_l       <= '0;
      cont_l      <= 1'b0;
      ce_l        <= 1'b0;
      ge_l        <= 1'b0;
      val_l       <= '0;
      sample_chan <= '0;
    end else if (go_pulse && go_start) begin
      div_l       <= div_code;
      cont_l      <= cont_en;
      ce_l        <= cmp_en;
      ge_l        <= cmp_ge;
      val_l       <= cmp_val;
      sample_chan <= chan_sel;
    end
  end

  // Approximation sequence.
  always_ff @(posedge conv_clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      acc    <= '0;
      trial  <= '0;
      cnt    <= '0;
    end else if (go_pulse) begin
      cnt <= '0;
      if (go_start) begin
        active <= 1'b1;
        acc    <= '0;
        trial  <= MSB_ONLY;
      end else begin
        active <= 1'b0;
        trial  <= '0;
      end
    end else if (tick) begin
      cnt <= '0;
      if (last_bit) begin
        if (cont_l) begin
          acc   <= '0;
          trial <= MSB_ONLY;
        end else begin
          acc    <= acc_next;
          trial  <= '0;
          active <= 1'b0;
        end
      end else begin
        acc   <= acc_next;
        trial <= trial >> 1;
      end
    end else if (active) begin
      cnt <= cnt + 3'd1;
    end
  end

  // Completion event and its held payload.
  always_ff @(posedge conv_clk or negedge rst_n) begin
    if (!rst_n) begin
      end_tgl  <= 1'b0;
      end_pass <= 1'b0;
      end_last <= 1'b0;
      end_data <= '0;
    end else if (!go_pulse && tick && last_bit) begin
      end_tgl  <= ~end_tgl;
      end_pass <= hit;
      end_last <= !cont_l;
      end_data <= acc_next;
    end
  end

endmodule

// File: rtl/sar_conv_ctrl.sv
module sar_conv_ctrl
  import adc_ctl_pkg::*;
#(
  parameter int RES_W   = 10,
  parameter int CH_W    = 4,
  parameter int NUM_SRC = 14,
  parameter int SYNC_N  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             alt_clk,
  input  logic             async_clk,
  input  logic             ctrl_wr,
  input  logic [CH_W-1:0]  chan_sel,
  input  logic [1:0]       clk_src,
  input  logic [1:0]       clk_div,
  input  logic             hw_trig_en,
  input  logic             cont_en,
  input  logic             cmp_en,
  input  logic             cmp_ge,
  input  logic [RES_W-1:0] cmp_val,
  input  logic             hw_trig,
  input  logic             rslt_rd,
  input  logic             cmp_in,
  output logic [RES_W-1:0] dac_code,
  output logic [CH_W-1:0]  sample_chan,
  output logic             mux_en,
  output logic             conv_active,
  output logic             busy,
  output logic             done_flag,
  output logic [RES_W-1:0] result
);

  // Bus-side control register.
  clk_src_e         src_q;
  logic [1:0]       div_q;
  logic [CH_W-1:0]  chan_q;
  logic             hw_q;
  logic             cont_q;
  logic             ce_q;
  logic             ge_q;
  logic [RES_W-1:0] val_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_q  <= SRC_BUS;
      div_q  <= '0;
      chan_q <= '0;
      hw_q   <= 1'b0;
      cont_q <= 1'b0;
      ce_q   <= 1'b0;
      ge_q   <= 1'b0;
      val_q  <= '0;
    end else if (ctrl_wr) begin
      src_q  <= clk_src_e'(clk_src);
      div_q  <= clk_div;
      chan_q <= chan_sel;
      hw_q   <= hw_trig_en;
      cont_q <= cont_en;
      ce_q   <= cmp_en;
      ge_q   <= cmp_ge;
      val_q  <= cmp_val;
    end
  end

  // Hardware trigger edge detection.
  logic [SYNC_N:0] trig_s;
  logic            trig_edge;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) trig_s <= '0;
    else        trig_s <= {trig_s[SYNC_N-1:0], hw_trig};
  end

  assign trig_edge = trig_s[SYNC_N-1] & ~trig_s[SYNC_N];

  // Start / abort events toward the conversion domain.
  logic start_evt;
  logic abort_evt;
  logic go_tgl;
  logic go_start;

  assign start_evt = ctrl_wr ? !hw_trig_en : (hw_q && trig_edge && !busy);
  assign abort_evt = ctrl_wr && hw_trig_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      go_tgl   <= 1'b0;
      go_start <= 1'b0;
    end else if (start_evt || abort_evt) begin
      go_tgl   <= ~go_tgl;
      go_start <= start_evt;
    end
  end

  // Conversion clock and conversion domain.
  logic             conv_clk;
  logic             go_pulse;
  logic [RES_W-1:0] trial;
  logic             end_tgl;
  logic             end_pass;
  logic             end_last;
  logic [RES_W-1:0] end_data;

  conv_clk_sel u_clk_sel (
    .bus_clk  (clk),
    .rst_n    (rst_n),
    .alt_clk  (alt_clk),
    .async_clk(async_clk),
    .src      (src_q),
    .conv_clk (conv_clk)
  );

  tgl_sync #(.STAGES(SYNC_N)) u_go_sync (
    .dst_clk(conv_clk),
    .rst_n  (rst_n),
    .tgl_in (go_tgl),
    .pulse  (go_pulse)
  );

  sar_engine #(
    .RES_W  (RES_W),
    .CH_W   (CH_W),
    .NUM_SRC(NUM_SRC)
  ) u_engine (
    .conv_clk   (conv_clk),
    .rst_n      (rst_n),
    .go_pulse   (go_pulse),
    .go_start   (go_start),
    .div_code   (div_q),
    .cont_en    (cont_q),
    .cmp_en     (ce_q),
    .cmp_ge     (ge_q),
    .cmp_val    (val_q),
    .chan_sel   (chan_q),
    .cmp_in     (cmp_in),
    .dac_code   (dac_code),
    .active     (conv_active),
    .sample_chan(sample_chan),
    .mux_en     (mux_en),
    .trial      (trial),
    .end_tgl    (end_tgl),
    .end_pass   (end_pass),
    .end_last   (end_last),
    .end_data   (end_data)
  );

  // Completion events back on the bus side.
  logic end_evt;
  logic acc_evt;
  logic pass_set;

  tgl_sync #(.STAGES(SYNC_N)) u_end_sync (
    .dst_clk(clk),
    .rst_n  (rst_n),
    .tgl_in (end_tgl),
    .pulse  (end_evt)
  );

  assign acc_evt  = end_evt && busy && !ctrl_wr;
  assign pass_set = acc_evt && end_pass;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
    end else if (start_evt) begin
      busy <= 1'b1;
    end else if (abort_evt || (acc_evt && end_last)) begin
      busy <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_flag <= 1'b0;
      result    <= '0;
    end else begin
      if (ctrl_wr)       done_flag <= 1'b0;
      else if (pass_set) done_flag <= 1'b1;
      else if (rslt_rd)  done_flag <= 1'b0;
      if (pass_set)      result    <= end_data;
    end
  end

endmodule

// File: rtl/sar_conv_chk.sv
module sar_conv_chk #(
  parameter int RES_W = 10
) (
  input logic             clk,
  input logic             rst_n,
  input logic             conv_clk,
  input logic             ctrl_wr,
  input logic             rslt_rd,
  input logic             done_flag,
  input logic             busy,
  input logic             pass_set,
  input logic             go_tgl,
  input logic [RES_W-1:0] result,
  input logic [RES_W-1:0] trial
);

  // R9
  rd_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rslt_rd && !pass_set) |=> !done_flag);

  // R9
  wr_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_wr |=> !done_flag);

  // R7
  flag_needs_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!done_flag && !pass_set) |=> !done_flag);

  // R7
  result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pass_set |=> $stable(result));

  // R5
  trig_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !ctrl_wr) |=> $stable(go_tgl));

  // R3
  trial_onehot_chk: assert property (@(posedge conv_clk) disable iff (!rst_n)
    $onehot0(trial));

endmodule

bind sar_conv_ctrl sar_conv_chk #(.RES_W(RES_W)) chk_i (
  .clk      (clk),
  .rst_n    (rst_n),
  .conv_clk (conv_clk),
  .ctrl_wr  (ctrl_wr),
  .rslt_rd  (rslt_rd),
  .done_flag(done_flag),
  .busy     (busy),
  .pass_set (pass_set),
  .go_tgl   (go_tgl),
  .result   (result),
  .trial    (trial)
);

// File: tb/sar_conv_ctrl_tb_top.sv
module sar_conv_ctrl_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int RES_W      = 10;
  localparam int CH_W       = 4;
  localparam int NVEC       = 8;

  logic             clk = 1'b0;
  logic             alt_clk = 1'b0;
  logic             async_clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             ctrl_wr = 1'b0;
  logic [CH_W-1:0]  chan_sel = '0;
  logic [1:0]       clk_src = '0;
  logic [1:0]       clk_div = '0;
  logic             hw_trig_en = 1'b0;
  logic             cont_en = 1'b0;
  logic             cmp_en = 1'b0;
  logic             cmp_ge = 1'b0;
  logic [RES_W-1:0] cmp_val = '0;
  logic             hw_trig = 1'b0;
  logic             rslt_rd = 1'b0;
  logic             cmp_in;
  logic [RES_W-1:0] dac_code;
  logic [CH_W-1:0]  sample_chan;
  logic             mux_en;
  logic             conv_active;
  logic             busy;
  logic             done_flag;
  logic [RES_W-1:0] result;

  logic [RES_W-1:0] ain = '0;

  always #(CLK_PERIOD/2) clk = ~clk;
  always #3 alt_clk = ~alt_clk;
  always #7 async_clk = ~async_clk;

  // Behavioural comparator: 1 when the input is at or above the DAC level.
  assign cmp_in = (ain >= dac_code);

  sar_conv_ctrl #(.RES_W(RES_W), .CH_W(CH_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .alt_clk(alt_clk), .async_clk(async_clk),
    .ctrl_wr(ctrl_wr), .chan_sel(chan_sel), .clk_src(clk_src), .clk_div(clk_div),
    .hw_trig_en(hw_trig_en), .cont_en(cont_en), .cmp_en(cmp_en), .cmp_ge(cmp_ge),
    .cmp_val(cmp_val), .hw_trig(hw_trig), .rslt_rd(rslt_rd), .cmp_in(cmp_in),
    .dac_code(dac_code), .sample_chan(sample_chan), .mux_en(mux_en),
    .conv_active(conv_active), .busy(busy), .done_flag(done_flag), .result(result)
  );

  typedef struct packed {
    logic [1:0]       src;
    logic [1:0]       div;
    logic [RES_W-1:0] level;
    logic             ce;
    logic             ge;
    logic [RES_W-1:0] thr;
  } vec_t;

  localparam vec_t VECS [NVEC] = '{
    '{2'd0, 2'd0, 10'd0,    1'b0, 1'b0, 10'd0},
    '{2'd0, 2'd1, 10'd1023, 1'b0, 1'b0, 10'd0},
    '{2'd1, 2'd0, 10'd341,  1'b0, 1'b0, 10'd0},
    '{2'd2, 2'd2, 10'd682,  1'b1, 1'b1, 10'd682},
    '{2'd3, 2'd3, 10'd681,  1'b1, 1'b1, 10'd682},
    '{2'd2, 2'd0, 10'd681,  1'b1, 1'b0, 10'd682},
    '{2'd3, 2'd1, 10'd682,  1'b1, 1'b0, 10'd682},
    '{2'd0, 2'd3, 10'd512,  1'b1, 1'b1, 10'd0}
  };

  int  n_checks = 0;
  int  n_fails  = 0;
  bit  run_done = 1'b0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic bit exp_accept(input vec_t v);
    if (!v.ce) return 1'b1;
    if (v.ge)  return v.level >= v.thr;
    return v.level < v.thr;
  endfunction

  task automatic wr_cfg(input logic [1:0] s, input logic [1:0] d, input logic [CH_W-1:0] ch,
                        input logic hw, input logic ct, input logic ce, input logic ge,
                        input logic [RES_W-1:0] thr);
    @(negedge clk);
    clk_src = s; clk_div = d; chan_sel = ch; hw_trig_en = hw;
    cont_en = ct; cmp_en = ce; cmp_ge = ge; cmp_val = thr;
    ctrl_wr = 1'b1;
    @(negedge clk);
    ctrl_wr = 1'b0;
  endtask

  task automatic rd_pulse();
    @(negedge clk);
    rslt_rd = 1'b1;
    @(negedge clk);
    rslt_rd = 1'b0;
  endtask

  task automatic wait_idle(output bit ok);
    ok = 1'b0;
    for (int k = 0; k < 4000; k++) begin
      @(negedge clk);
      if (!busy) begin
        ok = 1'b1;
        break;
      end
    end
  endtask

  task automatic measure_active(output int n);
    n = 0;
    for (int k = 0; k < 50; k++) begin
      @(negedge clk);
      if (conv_active) break;
    end
    while (conv_active && n < 1000) begin
      n++;
      @(negedge clk);
    end
  endtask

  // Watchdog
  initial begin
    repeat (150000) @(posedge clk);
    if (!run_done) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    bit ok;
    int n;
    logic [RES_W-1:0] prev_res;

    repeat (3) @(negedge clk);
    // R10 reset state
    chk(done_flag == 1'b0, "R10 done_flag", done_flag, 0);
    chk(busy == 1'b0, "R10 busy", busy, 0);
    chk(result == '0, "R10 result", result, 0);
    chk(dac_code == '0, "R10 dac_code", dac_code, 0);
    chk(conv_active == 1'b0, "R10 conv_active", conv_active, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // Table walk: R1, R3, R4, R6, R7, R9
    prev_res = '0;
    for (int i = 0; i < NVEC; i++) begin
      ain = VECS[i].level;
      wr_cfg(VECS[i].src, VECS[i].div, CH_W'(i), 1'b0, 1'b0,
             VECS[i].ce, VECS[i].ge, VECS[i].thr);
      wait_idle(ok);
      chk(ok, "R4 R1 conversion finished", int'(busy), 0);
      @(negedge clk);
      if (exp_accept(VECS[i])) prev_res = VECS[i].level;
      chk(done_flag == exp_accept(VECS[i]), "R7 flag", done_flag, int'(exp_accept(VECS[i])));
      chk(result == prev_res, "R3 R7 result", result, prev_res);
      chk(sample_chan == CH_W'(i), "R6 sample_chan", sample_chan, i);
      chk(mux_en == 1'b1, "R6 mux_en valid", mux_en, 1);
      if (done_flag) begin
        rd_pulse();
        chk(done_flag == 1'b0, "R9 read clears flag", done_flag, 0);
      end
    end

    // R2 divider timing on the bus clock
    for (int d = 0; d < 4; d++) begin
      ain = 10'd100;
      wr_cfg(2'd0, 2'(d), 4'd0, 1'b0, 1'b0, 1'b0, 1'b0, '0);
      measure_active(n);
      chk(n == RES_W * (1 << d), "R2 active cycles", n, RES_W * (1 << d));
      wait_idle(ok);
      rd_pulse();
    end

    // R1 halved bus clock doubles the duration
    wr_cfg(2'd1, 2'd1, 4'd0, 1'b0, 1'b0, 1'b0, 1'b0, '0);
    measure_active(n);
    chk(n >= 4 * RES_W - 1 && n <= 4 * RES_W + 1, "R1 half clock cycles", n, 4 * RES_W);
    wait_idle(ok);
    rd_pulse();

    // R9 control write clears the flag
    ain = 10'd300;
    wr_cfg(2'd0, 2'd0, 4'd0, 1'b0, 1'b0, 1'b0, 1'b0, '0);
    wait_idle(ok);
    @(negedge clk);
    chk(done_flag == 1'b1, "R9 flag set before write", done_flag, 1);
    wr_cfg(2'd0, 2'd0, 4'd0, 1'b0, 1'b0, 1'b1, 1'b1, 10'd1000);
    chk(done_flag == 1'b0, "R9 write clears flag", done_flag, 0);
    wait_idle(ok);
    @(negedge clk);
    chk(result == 10'd300, "R7 false compare keeps result", result, 300);

    // R4 write in hardware mode starts nothing
    ain = 10'd777;
    wr_cfg(2'd0, 2'd3, 4'd5, 1'b1, 1'b0, 1'b0, 1'b0, '0);
    repeat (60) @(negedge clk);
    chk(busy == 1'b0, "R4 hw mode write no start busy", busy, 0);
    chk(conv_active == 1'b0, "R4 hw mode write no start active", conv_active, 0);

    // R5 hardware trigger, second edge while busy ignored
    hw_trig = 1'b1;
    repeat (4) @(negedge clk);
    hw_trig = 1'b0;
    chk(busy == 1'b1, "R5 trigger starts", busy, 1);
    repeat (20) @(negedge clk);
    hw_trig = 1'b1;
    repeat (4) @(negedge clk);
    hw_trig = 1'b0;
    wait_idle(ok);
    @(negedge clk);
    chk(done_flag == 1'b1, "R5 triggered flag", done_flag, 1);
    chk(result == 10'd777, "R5 triggered result", result, 777);
    rd_pulse();
    repeat (300) @(negedge clk);
    chk(busy == 1'b0, "R5 edge while busy ignored busy", busy, 0);
    chk(done_flag == 1'b0, "R5 edge while busy ignored flag", done_flag, 0);

    // R6 reserved and last valid channel codes
    wr_cfg(2'd0, 2'd0, 4'd14, 1'b0, 1'b0, 1'b0, 1'b0, '0);
    wait_idle(ok);
    chk(mux_en == 1'b0, "R6 code 14 disables mux", mux_en, 0);
    wr_cfg(2'd0, 2'd0, 4'd15, 1'b0, 1'b0, 1'b0, 1'b0, '0);
    wait_idle(ok);
    chk(mux_en == 1'b0, "R6 code 15 disables mux", mux_en, 0);
    wr_cfg(2'd0, 2'd0, 4'd13, 1'b0, 1'b0, 1'b0, 1'b0, '0);
    wait_idle(ok);
    chk(mux_en == 1'b1, "R6 code 13 enables mux", mux_en, 1);
    rd_pulse();

    // R8 continuous compare waits silently for a true compare
    ain = 10'd100;
    wr_cfg(2'd0, 2'd0, 4'd0, 1'b0, 1'b1, 1'b1, 1'b1, 10'd600);
    repeat (400) @(negedge clk);
    chk(busy == 1'b1, "R8 still converting", busy, 1);
    chk(done_flag == 1'b0, "R8 no flag while false", done_flag, 0);
    chk(result == 10'd777, "R8 result untouched while false", result, 777);
    ain = 10'd700;
    ok = 1'b0;
    for (int k = 0; k < 500; k++) begin
      @(negedge clk);
      if (done_flag) begin
        ok = 1'b1;
        break;
      end
    end
    chk(ok, "R8 flag on true compare", done_flag, 1);
    chk(result == 10'd700, "R8 result on true compare", result, 700);
    wr_cfg(2'd0, 2'd0, 4'd0, 1'b0, 1'b0, 1'b0, 1'b0, '0);
    wait_idle(ok);
    chk(ok, "R8 leaves continuous mode", busy, 0);
    rd_pulse();

    run_done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  end

endmodule